// File: doc/BRIEF.md
# Periodic Strobe and Low-Battery Sequencer

This block produces the short, periodic indicator pulse of a battery-powered alarm. It also times the battery check so that the comparison happens only while that pulse draws current from the cell. The block runs from a reference clock. In normal operation, a prescaler turns that clock into a slow tick, and a fixed number of ticks separates two pulses. A select input switches the tick source to the rising edges of a fast external square wave, which shortens the interval during production test. The pulse width is always counted in reference clock cycles, so the comparator settling window does not change with the tick source.

The comparator output is passed through a synchronizer. In the final cycle of every pulse, the synchronized value is copied into a low-battery flag. A comparator enable output is high only while the comparator is needed. Two strap inputs are read once, just after power-on reset is released. If both straps are low, the block enters a test mode until the next reset. In test mode the comparator stays enabled and the horn test output follows the comparator continuously.

Top module: `lowbat_strobe_seq`

## Requirements
- R1: In slow-tick mode, successive rising edges of `ledStrobe` are exactly `DIV_CYC*PERIOD_TICKS` reference cycles apart.
- R2: `ledStrobe` stays high for exactly `PULSE_CYC` reference cycles, in both tick modes.
- R3: With `fastSel`=1, one tick is taken per rising edge of `fastWave`, so pulses start every `PERIOD_TICKS` wave periods.
- R4: Outside test mode, `cmpEn` is 1 exactly while `ledStrobe` is 1. In test mode, `cmpEn` is held at 1.
- R5: `lowBatt` changes only on the edge where `ledStrobe` falls. It takes the value of `cmpLow` (1 = supply below threshold) as seen through a `CMP_SYNC`-stage synchronizer in the last pulse cycle. Values of `cmpLow` outside the pulse are ignored.
- R6: While `rstN` is low, all outputs are 0. Every counter restarts on release, and the first pulse begins on the `DIV_CYC*PERIOD_TICKS`-th clock edge after release.
- R7: Test mode is entered only if `strapA` and `strapB` are both 0 on the first clock edge after release. It is then held until the next reset, and later strap changes have no effect.
- R8: In test mode, `hornTest` equals `cmpLow` delayed by `CMP_SYNC+1` cycles. Outside test mode, `hornTest` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous assert |
| strapA | input | 1 | Test strap, read once after reset release |
| strapB | input | 1 | Test strap, read once after reset release |
| fastSel | input | 1 | 1 selects the external fast wave as the tick source |
| fastWave | input | 1 | External square wave for accelerated timing |
| cmpLow | input | 1 | Comparator output, 1 = supply below threshold |
| ledStrobe | output | 1 | Indicator pulse, which also loads the battery |
| cmpEn | output | 1 | Comparator power enable |
| lowBatt | output | 1 | Latched low-battery flag |
| hornTest | output | 1 | Horn drive in test mode |

## Verification
On every cycle, the assertions check the following: the pulse width measured against a separate counter, that `lowBatt` moves only on a strobe falling edge, that the comparator is enabled whenever the strobe is, that the captured mode never changes between resets, that the horn stays quiet outside test mode, and that fast ticks are never adjacent. Other properties need whole scenarios run by the bench. These are the exact interval in each tick mode, the flag taking the in-pulse comparator value while contrary values around the pulse are ignored, the first pulse after a reset in mid-run, strap decoding and hold, and the horn latency in test mode.

// File: rtl/lowbat_seq_pkg.sv
package lowbat_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleNow;  // last cycle of the loaded pulse
    logic testMode;   // strap-selected test mode
  } seqCtrl_t;

  typedef enum logic {
    PH_WAIT  = 1'b0,
    PH_PULSE = 1'b1
  } phase_t;

endpackage

// File: rtl/lowbat_seq_dp.sv
module lowbat_seq_dp
  import lowbat_seq_pkg::*;
#(
  parameter int DIV_CYC  = 320,
  parameter int CMP_SYNC = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     fastSel,
  input  logic     fastWave,
  input  logic     cmpLow,
  input  seqCtrl_t ctrl,
  output logic     tick,
  output logic     lowBatt,
  output logic     hornTest
);

  localparam int WAVE_SYNC = CMP_SYNC + 1;

  logic slowTick;
  logic fastTick;
  logic [WAVE_SYNC-1:0] waveSync;
  logic [CMP_SYNC-1:0]  cmpSync;
  logic cmpSeen;

  // slow timebase: prescaler, or every cycle when no division is asked
  generate
    if (DIV_CYC > 1) begin : g_prescale
      localparam int DW = $clog2(DIV_CYC);
      localparam logic [DW-1:0] DIV_LAST = DW'(DIV_CYC - 1);
      logic [DW-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 preCnt <= '0;
        else if (preCnt == DIV_LAST) preCnt <= '0;
        else                       preCnt <= preCnt + DW'(1);
      end
      assign slowTick = (preCnt == DIV_LAST);
    end else begin : g_noprescale
      assign slowTick = 1'b1;
    end
  endgenerate

  // fast timebase: rising edge of the synchronized external wave
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waveSync <= '0;
    else       waveSync <= {waveSync[WAVE_SYNC-2:0], fastWave};
  end
  assign fastTick = waveSync[WAVE_SYNC-2] & ~waveSync[WAVE_SYNC-1];

  assign tick = fastSel ? fastTick : slowTick;

  // comparator synchronizer
  generate
    if (CMP_SYNC > 1) begin : g_cmpchain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cmpSync <= '0;
        else       cmpSync <= {cmpSync[CMP_SYNC-2:0], cmpLow};
      end
    end else begin : g_cmpsingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cmpSync <= '0;
        else       cmpSync <= cmpLow;
      end
    end
  endgenerate
  assign cmpSeen = cmpSync[CMP_SYNC-1];

  // flag: only written in the final loaded cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowBatt <= 1'b0;
    else if (ctrl.sampleNow) lowBatt <= cmpSeen;
  end

  // test horn follows the comparator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hornTest <= 1'b0;
    else       hornTest <= ctrl.testMode & cmpSeen;
  end

  // R3: edge detection never yields two adjacent fast ticks
  a_r3_fast_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    (fastSel && fastTick) |=> !fastTick);

endmodule

// File: rtl/lowbat_seq_ctrl.sv
module lowbat_seq_ctrl
  import lowbat_seq_pkg::*;
#(
  parameter int PERIOD_TICKS = 4000,
  parameter int PULSE_CYC    = 320
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     strapA,
  input  logic     strapB,
  input  logic     tick,
  output seqCtrl_t ctrl,
  output logic     ledStrobe,
  output logic     cmpEn
);

  localparam int TW = $clog2(PERIOD_TICKS + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [TW-1:0] PERIOD_LAST = TW'(PERIOD_TICKS - 1);
  localparam logic [PW-1:0] PULSE_LAST  = PW'(PULSE_CYC - 1);

  logic [TW-1:0] tickCnt;
  logic [PW-1:0] pulseCnt;
  phase_t        phase;
  logic          armed;
  logic          testMode;
  logic          startPulse;
  logic          lastCycle;

  assign startPulse = tick && (tickCnt == PERIOD_LAST);
  assign lastCycle  = (phase == PH_PULSE) && (pulseCnt == '0);

  // interval counter in ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    tickCnt <= '0;
    else if (tick) tickCnt <= startPulse ? '0 : tickCnt + TW'(1);
  end

  // pulse sequencer in reference cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_WAIT;
      pulseCnt <= '0;
    end else begin
      case (phase)
        PH_WAIT: if (startPulse) begin
          phase    <= PH_PULSE;
          pulseCnt <= PULSE_LAST;
        end
        PH_PULSE: begin
          if (pulseCnt == '0) phase <= PH_WAIT;
          else                pulseCnt <= pulseCnt - PW'(1);
        end
        default: phase <= PH_WAIT;
      endcase
    end
  end

  // strap capture on the first edge after release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      testMode <= 1'b0;
    end else if (!armed) begin
      armed    <= 1'b1;
      testMode <= ~strapA & ~strapB;
    end
  end

  assign ledStrobe      = (phase == PH_PULSE);
  assign cmpEn          = ledStrobe | testMode;
  assign ctrl.sampleNow = lastCycle;
  assign ctrl.testMode  = testMode;

  // R7: captured mode holds until the next reset
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> $stable(testMode));

  // R2: an interval never ends while a pulse is still running
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (phase == PH_WAIT));

endmodule

// File: rtl/lowbat_strobe_seq.sv
module lowbat_strobe_seq
  import lowbat_seq_pkg::*;
#(
  parameter int DIV_CYC      = 320,
  parameter int PERIOD_TICKS = 4000,
  parameter int PULSE_CYC    = 320,
  parameter int CMP_SYNC     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic strapA,
  input  logic strapB,
  input  logic fastSel,
  input  logic fastWave,
  input  logic cmpLow,
  output logic ledStrobe,
  output logic cmpEn,
  output logic lowBatt,
  output logic hornTest
);

  localparam int CW = $clog2(PULSE_CYC + 2);

  seqCtrl_t ctrl;
  logic     tick;

  lowbat_seq_ctrl #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .PULSE_CYC   (PULSE_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strapA   (strapA),
    .strapB   (strapB),
    .tick     (tick),
    .ctrl     (ctrl),
    .ledStrobe(ledStrobe),
    .cmpEn    (cmpEn)
  );

  lowbat_seq_dp #(
    .DIV_CYC (DIV_CYC),
    .CMP_SYNC(CMP_SYNC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .fastSel (fastSel),
    .fastWave(fastWave),
    .cmpLow  (cmpLow),
    .ctrl    (ctrl),
    .tick    (tick),
    .lowBatt (lowBatt),
    .hornTest(hornTest)
  );

  // independent width counter for the pulse check
  logic [CW-1:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hiCnt <= '0;
    else if (ledStrobe) hiCnt <= hiCnt + CW'(1);
    else                hiCnt <= '0;
  end

  // R2: pulse width in reference cycles
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ledStrobe) |-> (hiCnt == CW'(PULSE_CYC)));

  // R5: flag moves only when a pulse ends
  a_r5_flag_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (lowBatt != $past(lowBatt)) |-> $fell(ledStrobe));

  // R4: comparator powered for the whole pulse
  a_r4_enable_cover: assert property (@(posedge clk) disable iff (!rstN)
    ledStrobe |-> cmpEn);

  // R8: no horn unless in test mode
  a_r8_horn_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.testMode |-> !hornTest);

endmodule

// File: tb/lowbat_strobe_seq_tb.sv
module lowbat_strobe_seq_tb;

  localparam int DIV      = 4;
  localparam int PERIOD   = 10;
  localparam int PULSE    = 6;
  localparam int SYNC     = 2;
  localparam int SLOW_GAP = DIV * PERIOD;
  localparam int FAST_GAP = PERIOD * 3;  // wave period is 3 clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapA = 1'b1, strapB = 1'b1;
  logic fastSel = 1'b0, fastWave = 1'b0, cmpLow = 1'b0;
  logic ledStrobe, cmpEn, lowBatt, hornTest;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit waveOn = 1'b0;
  bit expQ[$];
  int expInterval = SLOW_GAP;
  string intervalTag = "R1 interval";
  int skipCnt = 0;
  bit expTest = 1'b0;

  lowbat_strobe_seq #(
    .DIV_CYC(DIV), .PERIOD_TICKS(PERIOD), .PULSE_CYC(PULSE), .CMP_SYNC(SYNC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .strapA(strapA), .strapB(strapB),
    .fastSel(fastSel), .fastWave(fastWave), .cmpLow(cmpLow),
    .ledStrobe(ledStrobe), .cmpEn(cmpEn), .lowBatt(lowBatt), .hornTest(hornTest)
  );

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc++;

  // toggles never coincide with a rising clock edge
  initial begin
    #2;
    forever begin
      #12;
      if (waveOn) fastWave = ~fastWave;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures intervals and widths, pops expected flags
  bit prevS = 1'b0;
  bit haveRise = 1'b0;
  int riseCyc = 0;
  int widthCnt = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      prevS = 1'b0; haveRise = 1'b0; widthCnt = 0;
    end else begin
      if (ledStrobe) widthCnt++;
      if (ledStrobe && !prevS) begin
        if (haveRise && skipCnt == 0) chk(intervalTag, cyc - riseCyc, expInterval);
        else if (haveRise) skipCnt--;
        riseCyc = cyc; haveRise = 1'b1; widthCnt = 1;
        chk("R4 cmpEn in pulse", cmpEn, 1);
      end
      if (!ledStrobe && prevS) begin
        chk("R2 pulse width", widthCnt, PULSE);
        chk("R4 cmpEn after pulse", cmpEn, expTest);
        if (expQ.size() > 0) begin
          bit e;
          e = expQ.pop_front();
          chk("R5 lowBatt", lowBatt, e);
        end
      end
      prevS = ledStrobe;
    end
  end

  task automatic doReset(input logic a, input logic b);
    @(negedge clk);
    rstN = 1'b0; strapA = a; strapB = b; cmpLow = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 reset ledStrobe", ledStrobe, 0);
    chk("R6 reset cmpEn", cmpEn, 0);
    chk("R6 reset lowBatt", lowBatt, 0);
    chk("R6 reset hornTest", hornTest, 0);
    rstN = 1'b1;
    repeat (SLOW_GAP - 1) @(posedge clk);
    @(negedge clk);
    chk("R6 no pulse before count", ledStrobe, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 first pulse", ledStrobe, 1);
  endtask

  // driver: contrary value between pulses, pattern value inside
  task automatic runPulses(input int n, input logic [7:0] pat);
    while (ledStrobe) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bit v;
      v = pat[i];
      cmpLow = ~v;
      do @(negedge clk); while (!ledStrobe);
      cmpLow = v;
      expQ.push_back(v);
      do @(negedge clk); while (ledStrobe);
      cmpLow = ~v;
    end
  endtask

  task automatic hornProbe(input bit follow);
    while (ledStrobe) @(negedge clk);
    cmpLow = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    cmpLow = 1'b1;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    chk("R8 horn latency", hornTest, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 horn follows", hornTest, follow);
    if (!ledStrobe) chk("R4 cmpEn idle", cmpEn, expTest);
    cmpLow = 1'b0;
    repeat (SYNC + 1) @(posedge clk);
    @(negedge clk);
    chk("R8 horn release", hornTest, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // normal mode, straps high at release
    doReset(1'b1, 1'b1);
    strapA = 1'b0; strapB = 1'b0;  // R7: too late to matter
    runPulses(5, 8'b0_1101);
    hornProbe(1'b0);                // R7/R8: still normal mode

    // accelerated timebase
    @(negedge clk);
    fastSel = 1'b1; waveOn = 1'b1;
    skipCnt = 2; expInterval = FAST_GAP; intervalTag = "R3 fast interval";
    runPulses(4, 8'b0110);
    @(negedge clk);
    fastSel = 1'b0; waveOn = 1'b0;
    skipCnt = 2; expInterval = SLOW_GAP; intervalTag = "R1 interval";
    runPulses(3, 8'b010);

    // mid-run reset with both straps low: test mode
    repeat (7) @(negedge clk);
    expTest = 1'b1;
    doReset(1'b0, 1'b0);
    strapA = 1'b1; strapB = 1'b1;   // R7: ignored after capture
    hornProbe(1'b1);
    runPulses(2, 8'b01);
    hornProbe(1'b1);

    // one strap low is not enough
    expTest = 1'b0;
    doReset(1'b0, 1'b1);
    hornProbe(1'b0);
    runPulses(2, 8'b10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule